// File: doc/BRIEF.md
# Bit-Field Extract and Insert Engine

This block reads or writes a bit field of 1 to 16 bits inside a stream of 16-bit words held in a word memory. The caller gives a byte pointer to a word, a 4-bit bit offset inside that word and a 4-bit length code. The field is one bit longer than the code says. In extract mode the engine returns the field zero-extended to 16 bits. In insert mode it puts the low bits of an accumulator value into the field. Every other memory bit keeps its value.

A field can cross into the following word. The engine then reads both words. On an insert it writes both back. Bit 0 of a word is the lowest position of the stream, and the words sit at ascending addresses, 2 bytes apart. At the end of an operation the engine returns an advanced offset and pointer, so a caller can walk through a packed stream one operation after another. It talks to a synchronous word memory whose read data appears one cycle after the read strobe.

Top module: `bitfield_engine`

## Requirements
- R1: With extract selected (op_insert=0), field_out at done is the (len_code+1)-bit field that begins at bit bit_off of the word at ptr_in, with all higher bits zero.
- R2: When bit_off+len_code+1 is greater than 16, an operation reads the word at ptr_in and then the word at ptr_in+2, and an extract takes the upper part of the field from bit 0 upward of the second word. Otherwise exactly one read is made.
- R3: With insert selected (op_insert=1), the low len_code+1 bits of acc_in are written to memory starting at bit bit_off of the word at ptr_in. All other bits of that word and of every other word are unchanged.
- R4: An insert whose field crosses a word boundary performs a read-modify-write on both words. The bits above the field in the second word and the bits below it in the first word are unchanged.
- R5: At done, off_out equals (bit_off+len_code+1) mod 16.
- R6: At done, ptr_out equals ptr_in+2 when bit_off+len_code+1 is 16 or more, and ptr_in otherwise. The sum of exactly 16 advances the pointer without reading a second word.
- R7: busy is high from the cycle after an accepted start until the cycle after done. done is a one-cycle pulse while busy. A start seen while busy is ignored and leaves no pending operation.
- R8: After reset busy, done, mem_rd and mem_wr are 0, and field_out, off_out and ptr_out are 0.
- R9: Length code 15 at offset 0 extracts or inserts a whole word, and code 0 handles a single bit.
- R10: An extract never asserts mem_wr, and mem_rd and mem_wr are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op_insert | input | 1 | 1 = insert, 0 = extract |
| bit_off | input | 4 | Bit offset of the field start in the first word |
| len_code | input | 4 | Field length minus one |
| acc_in | input | 16 | Source value for insert |
| ptr_in | input | ADDR_W | Byte address of the first word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| field_out | output | 16 | Extracted field, zero-extended |
| off_out | output | 4 | Advanced bit offset |
| ptr_out | output | ADDR_W | Advanced byte pointer |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_rd | output | 1 | Memory read strobe (data next cycle) |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |

## Verification
The bench builds the engine with its default parameters: 16-bit words, a 2-byte pointer step and a 16-bit address, placed over a 64-word memory model. With these values every offset and length code from 0 to 15 can be reached. That includes the sum of exactly 16, which advances the pointer without crossing a word, and the largest crossing, offset 15 with code 15. The model counts reads and writes, so the bench can check how many words each operation touches and that an insert leaves the neighbouring words alone.

// File: rtl/bfe_pkg.sv
package bfe_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RD0, ST_RD1, ST_CAP, ST_WR0, ST_WR1, ST_RES, ST_FIN
  } bfe_state_t;
endpackage

// File: rtl/bfe_merge.sv
module bfe_merge #(
  parameter int WORD_W = 16,
  localparam int OFF_W = $clog2(WORD_W),
  localparam int WIN_W = 2 * WORD_W
) (
  input  logic [WORD_W-1:0] lo_word,
  input  logic [WORD_W-1:0] hi_word,
  input  logic [OFF_W-1:0]  off,
  input  logic [OFF_W-1:0]  len,
  input  logic [WORD_W-1:0] acc,
  output logic [WORD_W-1:0] field,
  output logic [WORD_W-1:0] new_lo,
  output logic [WORD_W-1:0] new_hi,
  output logic              straddle,
  output logic              wrap,
  output logic [OFF_W-1:0]  next_off
);
  // ones in positions 0..len
  function automatic logic [WIN_W-1:0] low_ones(input logic [OFF_W-1:0] l);
    logic [WIN_W-1:0] m;
    m = '0;
    for (int i = 0; i < WORD_W; i++) if (i <= int'(l)) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [OFF_W:0] end_pos(input logic [OFF_W-1:0] o,
                                             input logic [OFF_W-1:0] l);
    return {1'b0, o} + {1'b0, l} + (OFF_W+1)'(1);
  endfunction

  logic [WIN_W-1:0] win, msk, ins, merged;
  logic [OFF_W:0]   epos;

  always_comb begin
    win      = {hi_word, lo_word};
    msk      = low_ones(len);
    epos     = end_pos(off, len);
    field    = WORD_W'((win >> off) & msk);
    ins      = (WIN_W'(acc) & msk) << off;
    merged   = (win & ~(msk << off)) | ins;
    new_lo   = merged[WORD_W-1:0];
    new_hi   = merged[WIN_W-1:WORD_W];
    straddle = epos > (OFF_W+1)'(WORD_W);
    wrap     = epos[OFF_W];
    next_off = epos[OFF_W-1:0];
  end
endmodule

// File: rtl/bfe_ctrl.sv
module bfe_ctrl
  import bfe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic straddle,
  input  logic is_ins,
  output logic load_in,
  output logic rd_en,
  output logic rd_hi,
  output logic cap_lo,
  output logic cap_hi,
  output logic wr_en,
  output logic wr_hi,
  output logic res_load,
  output logic busy,
  output logic done
);
  bfe_state_t st, st_nx;

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  always_comb begin
    st_nx    = st;
    load_in  = 1'b0;
    rd_en    = 1'b0;
    rd_hi    = 1'b0;
    cap_lo   = 1'b0;
    cap_hi   = 1'b0;
    wr_en    = 1'b0;
    wr_hi    = 1'b0;
    res_load = 1'b0;
    unique case (st)
      ST_IDLE: if (start) begin load_in = 1'b1; st_nx = ST_RD0; end
      ST_RD0:  begin rd_en = 1'b1; st_nx = ST_RD1; end
      ST_RD1:  begin
        cap_lo = 1'b1;
        if (straddle) begin rd_en = 1'b1; rd_hi = 1'b1; end
        st_nx = ST_CAP;
      end
      ST_CAP:  begin
        cap_hi = straddle;
        st_nx  = is_ins ? ST_WR0 : ST_RES;
      end
      ST_WR0:  begin wr_en = 1'b1; st_nx = straddle ? ST_WR1 : ST_RES; end
      ST_WR1:  begin wr_en = 1'b1; wr_hi = 1'b1; st_nx = ST_RES; end
      ST_RES:  begin res_load = 1'b1; st_nx = ST_FIN; end
      ST_FIN:  st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  assign busy = (st != ST_IDLE);
  assign done = (st == ST_FIN);

  assert_done_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  assert_busy_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  assert_idle_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/bitfield_engine.sv
module bitfield_engine #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 16,
  localparam int OFF_W = $clog2(WORD_W),
  localparam int STEP  = WORD_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_insert,
  input  logic [OFF_W-1:0]  bit_off,
  input  logic [OFF_W-1:0]  len_code,
  input  logic [WORD_W-1:0] acc_in,
  input  logic [ADDR_W-1:0] ptr_in,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] field_out,
  output logic [OFF_W-1:0]  off_out,
  output logic [ADDR_W-1:0] ptr_out,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);
  logic              op_q;
  logic [OFF_W-1:0]  off_q, len_q;
  logic [WORD_W-1:0] acc_q, w0_q, w1_q;
  logic [ADDR_W-1:0] ptr_q;

  logic load_in, rd_en, rd_hi, cap_lo, cap_hi, wr_en, wr_hi, res_load;
  logic [WORD_W-1:0] fld, nlo, nhi;
  logic              straddle, wrap;
  logic [OFF_W-1:0]  noff;

  bfe_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .straddle(straddle),
    .is_ins(op_q), .load_in(load_in), .rd_en(rd_en), .rd_hi(rd_hi),
    .cap_lo(cap_lo), .cap_hi(cap_hi), .wr_en(wr_en), .wr_hi(wr_hi),
    .res_load(res_load), .busy(busy), .done(done)
  );

  bfe_merge #(.WORD_W(WORD_W)) u_merge (
    .lo_word(w0_q), .hi_word(w1_q), .off(off_q), .len(len_q), .acc(acc_q),
    .field(fld), .new_lo(nlo), .new_hi(nhi), .straddle(straddle),
    .wrap(wrap), .next_off(noff)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q <= 1'b0; off_q <= '0; len_q <= '0; acc_q <= '0; ptr_q <= '0;
      w0_q <= '0; w1_q <= '0;
      field_out <= '0; off_out <= '0; ptr_out <= '0;
    end else begin
      if (load_in) begin
        op_q <= op_insert; off_q <= bit_off; len_q <= len_code;
        acc_q <= acc_in; ptr_q <= ptr_in; w1_q <= '0;
      end
      if (cap_lo) w0_q <= mem_rdata;
      if (cap_hi) w1_q <= mem_rdata;
      if (res_load) begin
        if (!op_q) field_out <= fld;
        off_out <= noff;
        ptr_out <= ptr_q + (wrap ? ADDR_W'(STEP) : '0);
      end
    end
  end

  logic hi_sel;
  assign hi_sel    = rd_en ? rd_hi : wr_hi;
  assign mem_addr  = ptr_q + (hi_sel ? ADDR_W'(STEP) : '0);
  assign mem_rd    = rd_en;
  assign mem_wr    = wr_en;
  assign mem_wdata = wr_hi ? nhi : nlo;

  assert_extract_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> op_q);
  assert_rd_wr_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((ptr_out != ptr_q) == (off_out <= off_q)));
  assert_second_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && rd_hi) |-> (mem_addr == ptr_q + ADDR_W'(STEP)));
endmodule

// File: tb/sim_bitfield_engine.sv
module sim_bitfield_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, op_insert = 1'b0;
  logic [3:0] bit_off = '0, len_code = '0;
  logic [15:0] acc_in = '0;
  logic [15:0] ptr_in = '0;
  logic busy, done, mem_rd, mem_wr;
  logic [15:0] field_out, mem_addr, mem_wdata, ptr_out;
  logic [15:0] mem_rdata = '0;
  logic [3:0] off_out;

  int total = 0, bad = 0, rd_cnt = 0, wr_cnt = 0, cyc = 0;
  logic [15:0] mem [64];
  logic [15:0] shadow [64];

  always #2 clk = ~clk;

  bitfield_engine u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_insert(op_insert),
    .bit_off(bit_off), .len_code(len_code), .acc_in(acc_in), .ptr_in(ptr_in),
    .busy(busy), .done(done), .field_out(field_out), .off_out(off_out),
    .ptr_out(ptr_out), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd) begin mem_rdata <= mem[mem_addr[6:1]]; rd_cnt <= rd_cnt + 1; end
    if (mem_wr) begin mem[mem_addr[6:1]] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_ext(input int idx, input int off, input int len);
    logic [31:0] w;
    w = {shadow[idx+1], shadow[idx]};
    return 16'(((w >> off) & ((32'h1 << (len + 1)) - 1)));
  endfunction

  task automatic ref_ins(input int idx, input int off, input int len, input logic [15:0] a);
    logic [31:0] w, m;
    w = {shadow[idx+1], shadow[idx]};
    m = (32'h1 << (len + 1)) - 1;
    w = (w & ~(m << off)) | ((32'(a) & m) << off);
    shadow[idx] = w[15:0];
    shadow[idx+1] = w[31:16];
  endtask

  task automatic run_op(input logic ins, input int off, input int len,
                        input logic [15:0] a, input logic [15:0] p);
    @(negedge clk);
    op_insert = ins; bit_off = 4'(off); len_code = 4'(len); acc_in = a; ptr_in = p;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  task automatic mem_match(input string tag);
    for (int i = 0; i < 64; i++)
      if (mem[i] !== shadow[i]) begin
        chk(1'b0, tag, {16'(i), mem[i]}, {16'(i), shadow[i]});
        return;
      end
    chk(1'b1, tag, 0, 0);
  endtask

  task automatic t_reset;
    chk(!busy && !done, "R8 busy/done", {busy, done}, 0);
    chk(!mem_rd && !mem_wr, "R8 strobes", {mem_rd, mem_wr}, 0);
    chk(field_out == 0 && off_out == 0 && ptr_out == 0, "R8 outputs",
        {field_out, ptr_out}, 0);
  endtask

  task automatic do_extract(input int off, input int len, input int idx, input string tag);
    int r0, w0;
    r0 = rd_cnt; w0 = wr_cnt;
    run_op(1'b0, off, len, 16'hFFFF, 16'(idx * 2));
    chk(field_out == ref_ext(idx, off, len), {tag, " R1 field"}, field_out,
        ref_ext(idx, off, len));
    chk(off_out == 4'(off + len + 1), {tag, " R5 offset"}, off_out, 4'(off + len + 1));
    chk(ptr_out == 16'(idx * 2 + ((off + len + 1 >= 16) ? 2 : 0)), {tag, " R6 ptr"},
        ptr_out, 16'(idx * 2 + ((off + len + 1 >= 16) ? 2 : 0)));
    chk((rd_cnt - r0) == ((off + len + 1 > 16) ? 2 : 1), {tag, " R2 reads"},
        rd_cnt - r0, (off + len + 1 > 16) ? 2 : 1);
    chk(wr_cnt == w0, {tag, " R10 no write"}, wr_cnt - w0, 0);
  endtask

  task automatic do_insert(input int off, input int len, input int idx,
                           input logic [15:0] a, input string tag);
    run_op(1'b1, off, len, a, 16'(idx * 2));
    ref_ins(idx, off, len, a);
    @(negedge clk);
    mem_match(tag);
    chk(off_out == 4'(off + len + 1), {tag, " R5 offset"}, off_out, 4'(off + len + 1));
    chk(ptr_out == 16'(idx * 2 + ((off + len + 1 >= 16) ? 2 : 0)), {tag, " R6 ptr"},
        ptr_out, 16'(idx * 2 + ((off + len + 1 >= 16) ? 2 : 0)));
  endtask

  task automatic t_extract_single;  do_extract(3, 4, 5, "R1 single");    endtask
  task automatic t_extract_cross;   do_extract(12, 9, 7, "R2 cross");    endtask
  task automatic t_extract_max;     do_extract(15, 15, 9, "R2 max cross"); endtask
  task automatic t_exact16;         do_extract(8, 7, 11, "R6 exact16");  endtask
  task automatic t_widths;
    do_extract(0, 15, 13, "R9 full word");
    do_extract(6, 0, 13, "R9 single bit");
  endtask
  task automatic t_insert_single;   do_insert(5, 6, 20, 16'h1234, "R3 ins single"); endtask
  task automatic t_insert_cross;    do_insert(10, 11, 22, 16'h0ABC, "R4 ins cross"); endtask
  task automatic t_insert_edges;
    do_insert(0, 15, 26, 16'hBEEF, "R9 ins full");
    do_insert(15, 0, 28, 16'h0000, "R9 ins bit15");
    do_extract(15, 0, 28, "R9 readback");
  endtask

  task automatic t_busy_ignore;
    int w0;
    w0 = wr_cnt;
    @(negedge clk);
    op_insert = 1'b0; bit_off = 4'd2; len_code = 4'd5; acc_in = 16'h0; ptr_in = 16'd60;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(busy, "R7 busy high", busy, 1);
    op_insert = 1'b1; bit_off = 4'd9; len_code = 4'd3; acc_in = 16'hFFFF; ptr_in = 16'd40;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    chk(field_out == ref_ext(30, 2, 5), "R7 first op kept", field_out, ref_ext(30, 2, 5));
    repeat (6) @(negedge clk);
    chk(!busy, "R7 no pending op", busy, 0);
    chk(wr_cnt == w0, "R7 ignored insert", wr_cnt - w0, 0);
    mem_match("R7 memory intact");
  endtask

  task automatic t_sweep;
    for (int k = 0; k < 8; k++) do_extract((k * 5) % 16, (k * 7 + 3) % 16, 40 + k, "R1 sweep");
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = 16'hA5C3 ^ 16'(i * 16'h1357);
      shadow[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_extract_single();
    t_extract_cross();
    t_extract_max();
    t_exact16();
    t_widths();
    t_insert_single();
    t_insert_cross();
    t_insert_edges();
    t_busy_ignore();
    t_sweep();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule